// File: doc/BRIEF.md
# Reversible Lifting Integer Rotator

This block rotates a pair of signed integers by a fixed angle using three lifting shears, each of which changes only one element of the pair by a rounded multiple of the other. Because every shear can be undone by subtracting the same rounded term that was added, the inverse mode recovers the original integers bit for bit, even though every product is truncated. Two fixed-point constants set the angle: the tangent of half the angle and the sine of the angle.

Each input sample carries a pair, a valid flag and a direction bit. Each of the three pipeline stages performs one shear, so the result leaves three cycles after it enters, and a new sample can enter on every cycle. Forward mode applies a rotation by minus the angle: a' ≈ a·cos + b·sin and b' ≈ −a·sin + b·cos. Inverse mode applies the three shears in reverse order with opposite signs. The internal and port width is DATA_W+2 bits, so forward results from DATA_W-bit inputs never wrap.

Top module: `lift_rotator`

## Requirements
- R1: While rst_n is low at a rising clock edge, out_valid, out_a and out_b become 0 after that edge.
- R2: out_valid equals in_valid delayed by exactly three clock cycles, with one result per cycle for back-to-back inputs and bubbles kept in place.
- R3: With in_mode = 0 (forward), the result is t = a + fl(KT·b), out_b = b − fl(KS·t), out_a = t + fl(KT·out_b), where fl(x) = floor(x / 2^FRAC_W) (arithmetic right shift), KT is the tangent constant and KS the sine constant, both signed with FRAC_W fraction bits.
- R4: With in_mode = 1 (inverse), the result is t = a − fl(KT·b), out_b = b + fl(KS·t), out_a = t − fl(KT·out_b), using the same rounding as R3.
- R5: Feeding a forward result back in inverse mode returns the original pair exactly, for every pair of DATA_W-bit signed inputs, including the most negative and most positive values.
- R6: Feeding an inverse result back in forward mode returns the original pair exactly for any DATA_W+2-bit pair, since every sum wraps modulo 2^(DATA_W+2) identically in both directions.
- R7: For DATA_W-bit inputs, each forward output differs by at most 3 from the ideal rotation by minus the angle.
- R8: The direction bit travels with its own sample; changing in_mode from one cycle to the next affects only that sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input pair is valid this cycle |
| in_mode | input | 1 | 0 = forward rotation, 1 = inverse rotation |
| in_a | input | DATA_W+2 | First element of the input pair, signed |
| in_b | input | DATA_W+2 | Second element of the input pair, signed |
| out_valid | output | 1 | Output pair is valid, three cycles after its input |
| out_a | output | DATA_W+2 | First element of the result, signed |
| out_b | output | DATA_W+2 | Second element of the result, signed |

## Verification
The bench builds the rotator with DATA_W = 8 (10-bit ports) and the 45-degree constants 6787 and 11585 at 14 fraction bits. At this width all 65,536 input pairs fit in one forward stream followed by one inverse stream, so exact recovery and the rounding-error bound are shown for every pair, not a sample. A further stream of full 10-bit pairs with mixed directions and bubbles checks each result against the arithmetic steps and then sends it back the opposite way to confirm that the pair returns unchanged.

// File: rtl/lift_rot_pkg.sv
// Shared definitions for the lifting rotator.
// Assumes: one direction bit per sample, 0 meaning forward.
package lift_rot_pkg;

    typedef enum logic {
        DIR_FWD = 1'b0,
        DIR_INV = 1'b1
    } dir_e;

    // Decide whether a shear adds its term: a forward-adding shear subtracts in inverse.
    function automatic logic shear_adds(logic fwd_adds, dir_e dir);
        return fwd_adds ^ (dir == DIR_INV);
    endfunction

endpackage

// File: rtl/lift_shear_stage.sv
// One registered lifting shear: updates one element of the pair by a
// rounded multiple of the other and passes the other element unchanged.
// Assumes: constant K is signed with FRAC_W fraction bits; sums wrap
// modulo 2^IW, which the opposite shear undoes exactly.
module lift_shear_stage
    import lift_rot_pkg::*;
#(
    parameter int IW       = 18,
    parameter int K_W      = 16,
    parameter int FRAC_W   = 14,
    parameter int K        = 0,
    parameter bit UPDATE_A = 1'b1,
    parameter bit FWD_ADD  = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_mode,
    input  logic [IW-1:0] in_a,
    input  logic [IW-1:0] in_b,
    output logic          out_valid,
    output logic          out_mode,
    output logic [IW-1:0] out_a,
    output logic [IW-1:0] out_b
);

    localparam int PW = IW + K_W;
    localparam logic signed [K_W-1:0] KC = K[K_W-1:0];

    logic signed [IW-1:0] src;
    logic signed [IW-1:0] dst;
    logic signed [PW-1:0] prod;
    logic signed [IW-1:0] term;
    logic signed [IW-1:0] dst_next;
    logic                 adds;

    // Pick the element that drives the term and the one that is updated.
    assign src = UPDATE_A ? $signed(in_b) : $signed(in_a);
    assign dst = UPDATE_A ? $signed(in_a) : $signed(in_b);

    // Scaled product rounded toward minus infinity, then kept to IW bits.
    assign prod = PW'(src) * PW'(KC);
    assign term = IW'(prod >>> FRAC_W);

    // Add or subtract the term according to this sample's direction.
    assign adds     = shear_adds(FWD_ADD, dir_e'(in_mode));
    assign dst_next = adds ? (dst + term) : (dst - term);

    // Pipeline register for the pair, direction and valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_mode  <= 1'b0;
            out_a     <= '0;
            out_b     <= '0;
        end else begin
            out_valid <= in_valid;
            out_mode  <= in_mode;
            out_a     <= UPDATE_A ? dst_next : in_a;
            out_b     <= UPDATE_A ? in_b : dst_next;
        end
    end

    // R2: a valid sample reaches the next stage one cycle later.
    a_r2_stage_valid: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R8: the direction bit travels with its sample.
    a_r8_mode_carried: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_mode == $past(in_mode));

    // R3: the element not being sheared leaves the stage unchanged.
    a_r3_other_kept: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (UPDATE_A ? (out_b == $past(in_b)) : (out_a == $past(in_a))));

    // R4: a zero source leaves the sheared element unchanged in either direction.
    a_r4_zero_source: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (UPDATE_A ? (in_b == '0) : (in_a == '0)))
        |=> (UPDATE_A ? (out_a == $past(in_a)) : (out_b == $past(in_b))));

endmodule

// File: rtl/lift_rotator.sv
// Reversible integer rotator: three registered lifting shears
// (a by b, b by a, a by b). Forward adds, subtracts, adds; inverse
// applies the same shears in the same slots with the signs flipped,
// which replays the forward steps in reverse.
// Assumes: forward inputs lie in DATA_W-bit signed range; constants are
// signed with FRAC_W fraction bits and magnitude at most 1.
module lift_rotator #(
    parameter int DATA_W = 16,
    parameter int K_W    = 16,
    parameter int FRAC_W = 14,
    parameter int K_TAN  = 6787,
    parameter int K_SIN  = 11585
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                in_mode,
    input  logic [DATA_W+1:0]   in_a,
    input  logic [DATA_W+1:0]   in_b,
    output logic                out_valid,
    output logic [DATA_W+1:0]   out_a,
    output logic [DATA_W+1:0]   out_b
);

    localparam int IW     = DATA_W + 2;
    localparam int STAGES = 3;

    logic          ch_v [0:STAGES];
    logic          ch_m [0:STAGES];
    logic [IW-1:0] ch_a [0:STAGES];
    logic [IW-1:0] ch_b [0:STAGES];

    // Entry of the shear chain.
    assign ch_v[0] = in_valid;
    assign ch_m[0] = in_mode;
    assign ch_a[0] = in_a;
    assign ch_b[0] = in_b;

    // Three shears: the middle one updates b with the sine constant and subtracts forward.
    for (genvar i = 0; i < STAGES; i++) begin : g_shear
        localparam bit ON_A = (i != 1);
        localparam int KSEL = (i == 1) ? K_SIN : K_TAN;
        lift_shear_stage #(
            .IW       (IW),
            .K_W      (K_W),
            .FRAC_W   (FRAC_W),
            .K        (KSEL),
            .UPDATE_A (ON_A),
            .FWD_ADD  (ON_A)
        ) u_stage (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (ch_v[i]),
            .in_mode   (ch_m[i]),
            .in_a      (ch_a[i]),
            .in_b      (ch_b[i]),
            .out_valid (ch_v[i+1]),
            .out_mode  (ch_m[i+1]),
            .out_a     (ch_a[i+1]),
            .out_b     (ch_b[i+1])
        );
    end

    // Chain exit drives the ports.
    assign out_valid = ch_v[STAGES];
    assign out_a     = ch_a[STAGES];
    assign out_b     = ch_b[STAGES];

    // R1: reset clears the output pair and its valid flag.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_a == '0 && out_b == '0));

    // R2: every output has a valid input three cycles earlier.
    a_r2_valid_origin: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 3));

    // R2: every valid input taken out of reset appears three cycles later.
    a_r2_valid_arrives: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid, 3) && $past(rst_n, 3) && $past(rst_n, 2) && $past(rst_n, 1))
        |-> out_valid);

endmodule

// File: tb/tb_lift_rotator.sv
// Bench: exhaustive forward/inverse sweep at DATA_W = 8, then mixed
// full-width streams with bubbles, each result sent back the other way.
module tb_lift_rotator;

    localparam int DW = 8;
    localparam int IW = DW + 2;
    localparam int FR = 14;
    localparam int KT = 6787;
    localparam int KS = 11585;
    localparam int NMAX = 65536;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_mode = 1'b0;
    logic [IW-1:0] in_a = '0;
    logic [IW-1:0] in_b = '0;
    logic          out_valid;
    logic [IW-1:0] out_a;
    logic [IW-1:0] out_b;

    int checks = 0;
    int errors = 0;

    int ga [NMAX];
    int gb [NMAX];
    int sa [NMAX];
    int sb [NMAX];
    bit sm [NMAX];
    bit sv [NMAX];
    int oa [NMAX];
    int ob [NMAX];

    always #10 clk = ~clk;

    lift_rotator #(
        .DATA_W (DW), .K_W (16), .FRAC_W (FR), .K_TAN (KT), .K_SIN (KS)
    ) dut (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_mode (in_mode),
        .in_a (in_a), .in_b (in_b),
        .out_valid (out_valid), .out_a (out_a), .out_b (out_b)
    );

    function automatic int wrapw(longint v);
        logic [IW-1:0] t;
        t = v[IW-1:0];
        return int'($signed(t));
    endfunction

    function automatic int term(int k, int y);
        longint p;
        p = longint'(k) * longint'(y);
        return wrapw(p >>> FR);
    endfunction

    function automatic void model(bit inv, int a, int b, output int ra, output int rb);
        int t;
        if (!inv) begin
            t  = wrapw(a + term(KT, b));
            rb = wrapw(b - term(KS, t));
            ra = wrapw(t + term(KT, rb));
        end else begin
            t  = wrapw(a - term(KT, b));
            rb = wrapw(b + term(KS, t));
            ra = wrapw(t - term(KT, rb));
        end
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Stream n samples from sa/sb/sm/sv, check valid timing and the
    // per-mode arithmetic, and store results in oa/ob.
    task automatic run_stream(int n);
        int ea, eb;
        for (int k = 0; k < n + 3; k++) begin
            @(negedge clk);
            if (k >= 3) begin
                chk(out_valid == sv[k-3], "R2", "out_valid", out_valid, sv[k-3]);
                if (sv[k-3]) begin
                    oa[k-3] = int'($signed(out_a));
                    ob[k-3] = int'($signed(out_b));
                    model(sm[k-3], sa[k-3], sb[k-3], ea, eb);
                    chk(oa[k-3] == ea && ob[k-3] == eb, sm[k-3] ? "R4" : "R3",
                        "pair (a*65536+b)", longint'(oa[k-3]) * 65536 + ob[k-3],
                        longint'(ea) * 65536 + eb);
                end
            end else begin
                chk(out_valid == 1'b0, "R2", "out_valid before first", out_valid, 0);
            end
            if (k < n) begin
                in_valid = sv[k];
                in_mode  = sm[k];
                in_a     = IW'(sa[k]);
                in_b     = IW'(sb[k]);
            end else begin
                in_valid = 1'b0;
                in_mode  = 1'b0;
            end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        int cn;
        real c45, s45, tr, sr;
        real ra1, rb1, ra2;

        // R1: reset state.
        repeat (4) @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        chk(out_a == '0 && out_b == '0, "R1", "out pair in reset",
            int'($signed(out_a)), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Phase A: every 8-bit pair forward (R3, R7).
        for (int i = 0; i < NMAX; i++) begin
            ga[i] = (i / 256) - 128;
            gb[i] = (i % 256) - 128;
            sa[i] = ga[i]; sb[i] = gb[i]; sm[i] = 1'b0; sv[i] = 1'b1;
        end
        run_stream(NMAX);

        c45 = $cos(3.14159265358979 / 4.0);
        s45 = $sin(3.14159265358979 / 4.0);
        tr  = real'(KT) / 16384.0;
        sr  = real'(KS) / 16384.0;
        for (int i = 0; i < NMAX; i++) begin
            real ia, ib;
            ia = real'(ga[i]) * c45 + real'(gb[i]) * s45;
            ib = -real'(ga[i]) * s45 + real'(gb[i]) * c45;
            ra1 = real'(ga[i]) + tr * real'(gb[i]);
            rb1 = real'(gb[i]) - sr * ra1;
            ra2 = ra1 + tr * rb1;
            checks++;
            if ((real'(oa[i]) - ia > 3.0) || (ia - real'(oa[i]) > 3.0) ||
                (real'(ob[i]) - ib > 3.0) || (ib - real'(ob[i]) > 3.0) ||
                (real'(oa[i]) - ra2 > 3.0) || (ra2 - real'(oa[i]) > 3.0)) begin
                errors++;
                $display("FAIL R7 rotation error: actual (%0d,%0d) expected (%f,%f)",
                         oa[i], ob[i], ia, ib);
            end
        end

        // Phase B: inverse of every forward result returns the input (R5, R4).
        for (int i = 0; i < NMAX; i++) begin
            sa[i] = oa[i]; sb[i] = ob[i]; sm[i] = 1'b1; sv[i] = 1'b1;
        end
        run_stream(NMAX);
        for (int i = 0; i < NMAX; i++) begin
            chk(oa[i] == ga[i] && ob[i] == gb[i], "R5", "round trip (a*65536+b)",
                longint'(oa[i]) * 65536 + ob[i], longint'(ga[i]) * 65536 + gb[i]);
        end

        // Phase C: full-width pairs, mixed directions, bubbles (R2, R3, R4, R8).
        cn = 1024;
        seed = 32'h1234_5678;
        for (int i = 0; i < cn; i++) begin
            seed = seed * 1103515245 + 12345;
            ga[i] = wrapw(longint'(seed >>> 8));
            seed = seed * 1103515245 + 12345;
            gb[i] = wrapw(longint'(seed >>> 8));
            sm[i] = bit'(i[0] ^ i[3]);
            sv[i] = (i % 7) != 6;
        end
        ga[0] = -512; gb[0] = -512;
        ga[1] = 511;  gb[1] = 511;
        ga[2] = -512; gb[2] = 511;
        ga[3] = 511;  gb[3] = -512;
        for (int i = 0; i < cn; i++) begin
            sa[i] = ga[i]; sb[i] = gb[i];
        end
        run_stream(cn);

        // Phase D: each result sent back the opposite way returns the input (R6).
        for (int i = 0; i < cn; i++) begin
            if (sv[i]) begin
                sa[i] = oa[i]; sb[i] = ob[i];
            end
            sm[i] = ~sm[i];
        end
        run_stream(cn);
        for (int i = 0; i < cn; i++) begin
            if (sv[i]) begin
                chk(oa[i] == ga[i] && ob[i] == gb[i], "R6", "reverse round trip",
                    longint'(oa[i]) * 65536 + ob[i], longint'(ga[i]) * 65536 + gb[i]);
            end
        end

        // R1: reset while samples are in flight clears the output.
        in_valid = 1'b1; in_mode = 1'b0; in_a = IW'(100); in_b = IW'(-50);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid after mid-stream reset", out_valid, 0);
        chk(out_a == '0 && out_b == '0, "R1", "out pair after mid-stream reset",
            int'($signed(out_a)), 0);
        in_valid = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule